// File: doc/BRIEF.md
# Single-Channel Peripheral DMA Engine

This block is one DMA channel that copies data items between a memory buffer and the data register of a peripheral. Software programs four channel registers through a small register port: the address of the peripheral's data register, the base address of the memory buffer, the number of items to move, and a control word. The control word selects the direction, whether the memory address advances, the channel enable and the completion interrupt enable. A status register holds a sticky completion flag.

Once enabled, the channel waits for the peripheral's request line. For each request it reads one item from the source and writes it to the destination over a simple master bus with request, address, write, write data, read data and ready. After each item it advances the memory address by the item size, if increment is on, and lowers the count by one. When the count reaches zero the channel disables itself, sets the completion flag and, if allowed, raises its interrupt.

Top module: `dma_channel`

## Requirements
- R1: After reset every register reads 0, `bus_req` is low and `irq` is low.
- R2: No bus request is issued while the enable bit (control bit 0) is clear or the count is zero, whatever the state of `dreq`.
- R3: Each item is one read at the source followed by one write of the read data to the destination. Control bit 1 set means memory is the source and the peripheral data register the destination. Control bit 1 clear means the reverse.
- R4: `dreq` is sampled only while no item is in flight. Each serviced item lowers the count (register 3) by exactly one. A request held high moves exactly the programmed number of items.
- R5: With control bit 2 set, the memory address (register 2) grows by the item size after every item. With bit 2 clear it stays fixed. The peripheral address (register 1) never changes by itself.
- R6: When the last item completes, status bit 0 (register 4) becomes 1 and the enable bit clears.
- R7: `irq` is high exactly when status bit 0 and the interrupt enable (control bit 3) are both 1.
- R8: Status bit 0 stays set until software writes register 4 with bit 0 equal to 1. Writing 0 leaves it set.
- R9: While the enable bit is set, writes to registers 1, 2 and 3 are ignored. The control register (register 0) stays writable.
- R10: Once `bus_req` is high it keeps its address, write flag and write data unchanged until `bus_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index (0 control, 1 peripheral address, 2 memory address, 3 count, 4 status) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational on `cfg_addr` |
| dreq | input | 1 | Peripheral transfer request |
| bus_req | output | 1 | Master bus request |
| bus_addr | output | ADDR_W | Master bus address |
| bus_write | output | 1 | 1 for a write phase, 0 for a read phase |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with `bus_ready` |
| bus_ready | input | 1 | Phase accepted by the slave |
| irq | output | 1 | Completion interrupt |

## Verification
A register write takes effect at the clock edge that samples the strobe, and a readback is combinational, so the bench reads each register half a cycle after it changes the index. An item takes at least three cycles: one to sample `dreq`, then one read phase and one write phase that each last until `bus_ready`. Count, address and completion results therefore trail a request by a variable number of cycles. The bench waits for them by polling the status register with a bound, or by waiting a fixed margin longer than the worst case. All sampling happens on the falling edge. The bus slave model inserts random wait states and checks that a pending phase holds steady.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FETCH = 2'd1,
    PH_STORE = 2'd2
  } phase_t;

  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_PADDR = 3'd1;
  localparam logic [2:0] REG_MADDR = 3'd2;
  localparam logic [2:0] REG_COUNT = 3'd3;
  localparam logic [2:0] REG_STAT  = 3'd4;

  localparam int CTL_EN  = 0;
  localparam int CTL_DIR = 1;
  localparam int CTL_INC = 2;
  localparam int CTL_IE  = 3;

  // memory pointer after one item
  function automatic logic [31:0] advance_addr(logic [31:0] a, logic inc, int unsigned step);
    return inc ? a + step : a;
  endfunction

  // remaining items after one item, floored at zero
  function automatic logic [31:0] count_after_item(logic [31:0] c);
    return (c == 32'd0) ? 32'd0 : c - 32'd1;
  endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int ITEM_BYTES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              item_done_i,
  output logic              en_o,
  output logic              dir_o,
  output logic              inc_o,
  output logic              ie_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic [ADDR_W-1:0] maddr_o,
  output logic              count_nz_o,
  output logic              done_o
);

  logic              en_q, dir_q, inc_q, ie_q, done_q;
  logic [ADDR_W-1:0] paddr_q, maddr_q;
  logic [CNT_W-1:0]  count_q;

  // named events
  logic wr_ctrl, wr_paddr, wr_maddr, wr_count, wr_clear;
  logic step_item, last_item;
  logic [ADDR_W-1:0] maddr_next;
  logic [CNT_W-1:0]  count_next;

  always_comb begin
    wr_ctrl    = cfg_we && (cfg_addr == REG_CTRL);
    wr_paddr   = cfg_we && (cfg_addr == REG_PADDR) && !en_q;
    wr_maddr   = cfg_we && (cfg_addr == REG_MADDR) && !en_q;
    wr_count   = cfg_we && (cfg_addr == REG_COUNT) && !en_q;
    wr_clear   = cfg_we && (cfg_addr == REG_STAT) && cfg_wdata[0];
    step_item  = item_done_i && (count_q != '0);
    last_item  = item_done_i && (count_q == CNT_W'(1));
    maddr_next = ADDR_W'(advance_addr(32'(maddr_q), inc_q, ITEM_BYTES));
    count_next = CNT_W'(count_after_item(32'(count_q)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      dir_q   <= 1'b0;
      inc_q   <= 1'b0;
      ie_q    <= 1'b0;
      done_q  <= 1'b0;
      paddr_q <= '0;
      maddr_q <= '0;
      count_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= cfg_wdata[CTL_EN];
        dir_q <= cfg_wdata[CTL_DIR];
        inc_q <= cfg_wdata[CTL_INC];
        ie_q  <= cfg_wdata[CTL_IE];
      end
      if (wr_paddr) paddr_q <= cfg_wdata[ADDR_W-1:0];
      if (wr_maddr) maddr_q <= cfg_wdata[ADDR_W-1:0];
      if (wr_count) count_q <= cfg_wdata[CNT_W-1:0];
      if (wr_clear) done_q <= 1'b0;
      if (step_item) begin
        maddr_q <= maddr_next;
        count_q <= count_next;
      end
      if (last_item) begin
        done_q <= 1'b1;
        en_q   <= 1'b0;
      end
    end
  end

  always_comb begin
    case (cfg_addr)
      REG_CTRL:  cfg_rdata = {28'd0, ie_q, inc_q, dir_q, en_q};
      REG_PADDR: cfg_rdata = 32'(paddr_q);
      REG_MADDR: cfg_rdata = 32'(maddr_q);
      REG_COUNT: cfg_rdata = 32'(count_q);
      REG_STAT:  cfg_rdata = {31'd0, done_q};
      default:   cfg_rdata = 32'd0;
    endcase
  end

  assign en_o       = en_q;
  assign dir_o      = dir_q;
  assign inc_o      = inc_q;
  assign ie_o       = ie_q;
  assign paddr_o    = paddr_q;
  assign maddr_o    = maddr_q;
  assign count_nz_o = (count_q != '0);
  assign done_o     = done_q;

  // R4: one item takes exactly one off the count
  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_item |=> (count_q == $past(count_q) - CNT_W'(1)));

  // R6: final item leaves the flag set and the channel off
  assert_done_on_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    last_item |=> (done_q && !en_q));

  // R8: flag holds unless cleared by a write of one
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !wr_clear) |=> done_q);

  // R9: channel setup frozen while enabled, apart from item progress
  assert_setup_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !item_done_i) |=> ($stable(paddr_q) && $stable(maddr_q) && $stable(count_q)));

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en_i,
  input  logic              dir_i,
  input  logic              count_nz_i,
  input  logic              dreq_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [ADDR_W-1:0] maddr_i,
  input  logic              bus_ready_i,
  input  logic [DW-1:0]     bus_rdata_i,
  output logic              bus_req_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_write_o,
  output logic [DW-1:0]     bus_wdata_o,
  output logic              item_done_o
);

  phase_t            phase_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [DW-1:0]     hold_q;

  // named events
  logic take_req, fetch_ack, store_ack;

  always_comb begin
    take_req  = (phase_q == PH_IDLE) && chan_en_i && count_nz_i && dreq_i;
    fetch_ack = (phase_q == PH_FETCH) && bus_ready_i;
    store_ack = (phase_q == PH_STORE) && bus_ready_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      hold_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (take_req) begin
          src_q   <= dir_i ? maddr_i : paddr_i;
          dst_q   <= dir_i ? paddr_i : maddr_i;
          phase_q <= PH_FETCH;
        end
        PH_FETCH: if (fetch_ack) begin
          hold_q  <= bus_rdata_i;
          phase_q <= PH_STORE;
        end
        PH_STORE: if (store_ack) phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_req_o   = (phase_q != PH_IDLE);
    bus_write_o = (phase_q == PH_STORE);
    bus_addr_o  = (phase_q == PH_STORE) ? dst_q : src_q;
    bus_wdata_o = hold_q;
    item_done_o = store_ack;
  end

  // R2: a quiet bus stays quiet while the channel cannot run
  assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req_o && !(chan_en_i && count_nz_i)) |=> !bus_req_o);

  // R3: an accepted read is followed by a write of the returned data
  assert_read_then_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_write_o && bus_ready_i) |=>
      (bus_req_o && bus_write_o && (bus_wdata_o == $past(bus_rdata_i))));

  // R10: a pending phase holds steady
  assert_phase_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_ready_i) |=>
      (bus_req_o && $stable(bus_addr_o) && $stable(bus_write_o) && $stable(bus_wdata_o)));

endmodule

// File: rtl/dma_channel.sv
module dma_channel #(
  parameter int ADDR_W     = 32,
  parameter int DW         = 8,
  parameter int CNT_W      = 16,
  parameter int ITEM_BYTES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              dreq,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_write,
  output logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     bus_rdata,
  input  logic              bus_ready,
  output logic              irq
);

  logic              en, dir, inc, ie, count_nz, done, item_done;
  logic [ADDR_W-1:0] paddr, maddr;

  dma_chan_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .ITEM_BYTES(ITEM_BYTES)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .item_done_i(item_done),
    .en_o(en), .dir_o(dir), .inc_o(inc), .ie_o(ie),
    .paddr_o(paddr), .maddr_o(maddr), .count_nz_o(count_nz), .done_o(done)
  );

  dma_xfer_engine #(
    .ADDR_W(ADDR_W), .DW(DW)
  ) u_engine (
    .clk(clk), .rst_n(rst_n),
    .chan_en_i(en), .dir_i(dir), .count_nz_i(count_nz), .dreq_i(dreq),
    .paddr_i(paddr), .maddr_i(maddr),
    .bus_ready_i(bus_ready), .bus_rdata_i(bus_rdata),
    .bus_req_o(bus_req), .bus_addr_o(bus_addr), .bus_write_o(bus_write),
    .bus_wdata_o(bus_wdata), .item_done_o(item_done)
  );

  assign irq = done && ie;

  // R7: interrupt only when completion is flagged and allowed
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cfg_addr != 3'd4 || cfg_rdata[0]));

endmodule

// File: tb/dma_channel_bench.sv
module dma_channel_bench;

  localparam int ADDR_W = 32;
  localparam int DW     = 8;
  localparam int ITEM   = 1;
  localparam logic [31:0] PER_ADDR = 32'h4000_0010;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [2:0]        cfg_addr = 3'd0;
  logic [31:0]       cfg_wdata = 32'd0;
  logic [31:0]       cfg_rdata;
  logic              dreq = 1'b0;
  logic              bus_req;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_write;
  logic [DW-1:0]     bus_wdata;
  logic [DW-1:0]     bus_rdata = '0;
  logic              bus_ready = 1'b0;
  logic              irq;

  int nchk = 0, nfail = 0;
  logic [7:0] mem [0:255];
  logic [7:0] exp_mem [0:255];
  logic [7:0] per_out [0:15];
  int per_wr_n = 0, per_rd_n = 0, n_rd = 0, n_wr = 0;
  int max_wait = 0, wait_left = 0, req_seen = 0, hold_err = 0;
  logic [7:0] pbase = 8'd0;
  logic pend = 1'b0;
  logic [ADDR_W-1:0] p_addr;
  logic p_write;
  logic [DW-1:0] p_wdata;

  dma_channel u_dma_channel (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dreq(dreq),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_write(bus_write),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready), .irq(irq)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] per_byte(logic [7:0] pb, int i);
    return 8'(int'(pb) + i * 29 + 5);
  endfunction

  function automatic logic [31:0] exp_final(logic [31:0] base, logic inc, int n);
    return inc ? base + 32'(n * ITEM) : base;
  endfunction

  // bus slave model with wait states and hold checking
  always @(negedge clk) begin
    if (bus_req) req_seen++;
    if (pend && !(bus_req && bus_addr == p_addr && bus_write == p_write &&
                  (!p_write || bus_wdata == p_wdata))) hold_err++;
    if (bus_ready) bus_ready = 1'b0;
    else if (bus_req) begin
      if (wait_left == 0) begin
        if (bus_write) begin
          n_wr++;
          if (bus_addr == PER_ADDR) begin per_out[per_wr_n[3:0]] = bus_wdata; per_wr_n++; end
          else mem[bus_addr[7:0]] = bus_wdata;
        end else begin
          n_rd++;
          if (bus_addr == PER_ADDR) begin bus_rdata = per_byte(pbase, per_rd_n); per_rd_n++; end
          else bus_rdata = mem[bus_addr[7:0]];
        end
        bus_ready = 1'b1;
        wait_left = (max_wait == 0) ? 0 : int'($urandom_range(0, max_wait));
      end else wait_left--;
    end
    pend = bus_req && !bus_ready;
    p_addr = bus_addr; p_write = bus_write; p_wdata = bus_wdata;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic wait_done(string req);
    logic [31:0] s;
    int t;
    s = 0;
    for (t = 0; t < 3000; t++) begin
      cfg_read(3'd4, s);
      if (s[0]) break;
    end
    chk(req, "completion within bound", {31'd0, s[0]}, 32'd1);
  endtask

  task automatic setup(logic dir, logic inc, logic ie, logic [31:0] base, int n, int mw);
    max_wait = mw; per_wr_n = 0; per_rd_n = 0; n_rd = 0; n_wr = 0;
    pbase = 8'($urandom_range(0, 255));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    exp_mem = mem;
    cfg_write(3'd0, 32'd0);
    cfg_write(3'd4, 32'd1);
    cfg_write(3'd1, PER_ADDR);
    cfg_write(3'd2, base);
    cfg_write(3'd3, 32'(n));
    cfg_write(3'd0, {28'd0, ie, inc, dir, 1'b1});
  endtask

  task automatic run_xfer(logic dir, logic inc, logic ie, logic [31:0] base, int n, int mw, bit probe);
    logic [31:0] v;
    int bad, a;
    setup(dir, inc, ie, base, n, mw);
    if (probe) begin
      cfg_write(3'd3, 32'd77);
      cfg_write(3'd1, 32'h55);
      cfg_write(3'd2, 32'hEE);
    end
    @(negedge clk); dreq = 1'b1;
    wait_done("R6");
    @(negedge clk); dreq = 1'b0;
    repeat (4) @(negedge clk);
    chk("R4", "reads", 32'(n_rd), 32'(n));
    chk("R4", "writes", 32'(n_wr), 32'(n));
    cfg_read(3'd3, v); chk("R4", "count at end", v, 32'd0);
    cfg_read(3'd2, v); chk("R5", "memory address at end", v, exp_final(base, inc, n));
    cfg_read(3'd1, v); chk(probe ? "R9" : "R5", "peripheral address", v, PER_ADDR);
    cfg_read(3'd0, v); chk("R6", "enable cleared", {31'd0, v[0]}, 32'd0);
    cfg_read(3'd4, v); chk("R6", "status flag", v, 32'd1);
    chk("R7", "irq", {31'd0, irq}, {31'd0, ie});
    bad = 0;
    for (int i = 0; i < n; i++) begin
      a = int'(base) + (inc ? i * ITEM : 0);
      if (dir) begin
        if (per_out[i] !== exp_mem[a]) bad++;
      end else exp_mem[a] = per_byte(pbase, i);
    end
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk("R3", dir ? "bytes to peripheral" : "bytes to memory", 32'(bad), 32'd0);
    chk("R10", "held phases", 32'(hold_err), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int rs;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int r = 0; r < 5; r++) begin
      cfg_read(3'(r), v); chk("R1", "register after reset", v, 32'd0);
    end
    chk("R1", "bus_req after reset", {31'd0, bus_req}, 32'd0);
    chk("R1", "irq after reset", {31'd0, irq}, 32'd0);

    // R2 disabled channel ignores request
    cfg_write(3'd3, 32'd4);
    rs = req_seen;
    @(negedge clk); dreq = 1'b1;
    repeat (20) @(negedge clk);
    dreq = 1'b0;
    chk("R2", "bus requests while disabled", 32'(req_seen - rs), 32'd0);
    cfg_read(3'd3, v); chk("R2", "count while disabled", v, 32'd4);

    // R2 enabled with zero count
    cfg_write(3'd3, 32'd0);
    cfg_write(3'd0, 32'h1);
    rs = req_seen;
    @(negedge clk); dreq = 1'b1;
    repeat (20) @(negedge clk);
    dreq = 1'b0;
    chk("R2", "bus requests with zero count", 32'(req_seen - rs), 32'd0);

    // memory to peripheral, with frozen-register probe (R9)
    run_xfer(1'b1, 1'b1, 1'b1, 32'h10, 5, 2, 1'b1);

    // R8 sticky flag
    cfg_write(3'd4, 32'd0);
    cfg_read(3'd4, v); chk("R8", "flag after writing zero", v, 32'd1);
    chk("R8", "irq after writing zero", {31'd0, irq}, 32'd1);
    cfg_write(3'd4, 32'd1);
    cfg_read(3'd4, v); chk("R8", "flag after writing one", v, 32'd0);
    chk("R7", "irq after clear", {31'd0, irq}, 32'd0);

    // peripheral to memory, increment on, irq disabled
    run_xfer(1'b0, 1'b1, 1'b0, 32'h40, 4, 0, 1'b0);
    // peripheral to memory, fixed address
    run_xfer(1'b0, 1'b0, 1'b1, 32'h80, 3, 1, 1'b0);

    // R4 one item per request pulse, zero wait states
    setup(1'b1, 1'b1, 1'b1, 32'h20, 3, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); dreq = 1'b1;
      @(negedge clk); dreq = 1'b0;
      repeat (8) @(negedge clk);
      cfg_read(3'd3, v); chk("R4", "count after one pulse", v, 32'(2 - k));
    end
    cfg_read(3'd4, v); chk("R6", "flag after pulses", v, 32'd1);
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
    repeat (8) @(negedge clk);
    chk("R2", "reads after completion", 32'(n_rd), 32'd3);

    // random transfers
    for (int t = 0; t < 8; t++) begin
      run_xfer(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               32'($urandom_range(0, 20) * 8), int'($urandom_range(1, 12)),
               int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule